// File: doc/BRIEF.md
# Destination Address Filter

This block sits on the receive path of an Ethernet MAC. It decides whether a frame is kept, based on the frame's 48-bit destination address. The address arrives in one piece with a one-cycle strobe. The first byte on the wire is in bits 7:0, and within each byte the least significant bit is sent first. One clock later the block returns an accept decision and a 6-bit status word that is stored with the frame.

Software programs the filter through a 16-bit register write port. The filter holds these settings:
- four 48-bit exact-match slots: the station address plus three multicast addresses;
- a 64-bin multicast hash table, built from CRC-32 of the address;
- two override bits: accept every multicast frame, and accept every frame.

Each slot is written as three 16-bit words. The word at slot offset +0 carries address bits 15:0, +2 carries bits 31:16 and +4 carries bits 47:32.

Top module: `dest_addr_filter`

## Requirements
- R1: While reset is asserted and after it is released, `res_valid` and `res_accept` are 0 and `res_status` is 0. Reset clears the hash table and both override bits, and sets every slot to all-ones, which means unused.
- R2: `res_valid` is 1 on the clock edge that samples `da_valid`, and is 0 otherwise. When `res_valid` is 0, `res_accept` and `res_status` are 0.
- R3: The address with all 48 bits set is always accepted, and its status is exactly 0x20 (bit 5 only).
- R4: A unicast address (bit 0 = 0) is accepted only when it equals slot 0, unless the accept-all bit is set. On a match the status is 0x04, with bit 2 set and index 0. Otherwise the status is 0x00.
- R5: A multicast address (bit 0 = 1, not all-ones) sets status bit 4. If it equals slot 1, 2 or 3, it is accepted with bit 2 set and the slot number in bits 1:0. When several slots hold the same address, the lowest slot number wins. A slot holding all-ones never matches.
- R6: The hash value h is taken from the CRC-32 of the address. The CRC uses reflected polynomial 0xEDB88320 and starts from 0xFFFFFFFF. It processes bit 0 to bit 47 in turn and applies no final inversion. h is CRC bits 31:26. h selects hash word h[5:4] and bit (15 − h[3:0]) of that word. A multicast address with no slot match whose hash bit is set is accepted with status bit 3 set.
- R7: When a slot match and a hash hit happen together, the slot match wins: bit 2 and the index are reported, and bit 3 is 0.
- R8: Control bit 5 (the multicast override) accepts every multicast address without changing the status bits. It has no effect on unicast addresses.
- R9: Control bit 8 (the accept-all override) accepts every address without changing the status bits.
- R10: The register map is as follows. Offset 0x00 is control. Offsets 0x60, 0x62, 0x64 and 0x66 are hash words 0 to 3. Slot n starts at 0x68 + 8·n, with words at +0, +2 and +4. Writes to any other offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 16 | Register write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, first byte in bits 7:0 |
| res_valid | output | 1 | Result strobe, one cycle after `da_valid` |
| res_accept | output | 1 | Frame is kept |
| res_status | output | 6 | Bit 5 broadcast, bit 4 multicast, bit 3 hash hit, bit 2 slot hit, bits 1:0 slot index |

## Verification
A corrupted slot or hash word shows up only on the next address that touches it. It appears as a wrong accept bit or a wrong slot index on the very next `res_valid` cycle. A bad CRC bit moves the hash bin, so a multicast address that should be kept is dropped, or one that should be dropped is kept. The bench therefore feeds addresses taken from the programmed slots and their hash bins, mixed with random ones. It compares every result cycle against a behavioural model, so any divergence is caught within one clock of the address that exposes it.

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
  parameter int AW          = 8,
  parameter int NSLOT       = 4,
  parameter int HWORDS      = 4,
  parameter int CTRL_OFS    = 'h00,
  parameter int HASH_OFS    = 'h60,
  parameter int SLOT_OFS    = 'h68,
  parameter int SLOT_STRIDE = 8,
  parameter int ALLM_BIT    = 5,
  parameter int PROM_BIT    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [AW-1:0]                 cfg_addr,
  input  logic [15:0]                   cfg_wdata,
  input  logic                          da_valid,
  input  logic [47:0]                   da,
  output logic                          res_valid,
  output logic                          res_accept,
  output logic [$clog2(NSLOT)+3:0]      res_status
);
  localparam int IDXW  = $clog2(NSLOT);
  localparam int SW    = IDXW + 4;
  localparam int HBITS = $clog2(HWORDS * 16);

  logic        allm_q, prom_q;
  logic [47:0] slot_q [NSLOT];
  logic [15:0] hash_q [HWORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allm_q <= 1'b0;
      prom_q <= 1'b0;
      for (int i = 0; i < NSLOT; i++) slot_q[i] <= '1;
      for (int j = 0; j < HWORDS; j++) hash_q[j] <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == AW'(CTRL_OFS)) begin
        allm_q <= cfg_wdata[ALLM_BIT];
        prom_q <= cfg_wdata[PROM_BIT];
      end
      for (int j = 0; j < HWORDS; j++)
        if (cfg_addr == AW'(HASH_OFS + 2 * j)) hash_q[j] <= cfg_wdata;
      for (int i = 0; i < NSLOT; i++)
        for (int w = 0; w < 3; w++)
          if (cfg_addr == AW'(SLOT_OFS + i * SLOT_STRIDE + 2 * w))
            slot_q[i][16*w +: 16] <= cfg_wdata;
    end
  end

  function automatic logic [HBITS-1:0] hash_of(input logic [47:0] a);
    logic [31:0] c;
    c = '1;
    for (int i = 0; i < 48; i++)
      c = (c >> 1) ^ ((c[0] ^ a[i]) ? 32'hEDB88320 : 32'h0);
    return c[31 -: HBITS];
  endfunction

  logic [HBITS-1:0] h;
  logic [15:0]      hword;
  logic             hbit;
  assign h     = hash_of(da);
  assign hword = hash_q[h[HBITS-1:4]];
  assign hbit  = hword[4'd15 - h[3:0]];

  logic is_bc, is_mc;
  assign is_bc = &da;
  assign is_mc = da[0] & ~is_bc;

  logic [NSLOT-1:0] hit;
  for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
    assign hit[g] = (slot_q[g] == da) && !(&slot_q[g]);
  end

  logic            ex, hh, acc;
  logic [IDXW-1:0] idx;
  logic [SW-1:0]   st;

  always_comb begin
    ex  = 1'b0;
    idx = '0;
    if (is_mc) begin
      for (int i = NSLOT - 1; i >= 1; i--)
        if (hit[i]) begin
          ex  = 1'b1;
          idx = IDXW'(i);
        end
    end else if (!is_bc && hit[0]) begin
      ex = 1'b1;
    end
    hh  = is_mc & ~ex & hbit;
    acc = prom_q | is_bc | ex | hh | (is_mc & allm_q);
    st  = is_bc ? SW'(1) << (SW - 1) : {1'b0, is_mc, hh, ex, idx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_status <= '0;
    end else begin
      res_valid  <= da_valid;
      res_accept <= da_valid & acc;
      res_status <= da_valid ? st : '0;
    end
  end
endmodule

// File: rtl/dest_addr_filter_chk.sv
module dest_addr_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        da_valid,
  input logic [47:0] da,
  input logic        prom,
  input logic [47:0] station,
  input logic        res_valid,
  input logic        res_accept,
  input logic [5:0]  res_status
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> res_valid);
  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> !res_valid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_accept && res_status == 6'h00));
  // R3
  bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && (&da)) |=> (res_accept && res_status == 6'h20));
  // R4
  unicast_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !da[0] && !prom && da != station) |=> !res_accept);
  // R7
  exact_over_hash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_status[3] && res_status[2]));
  // R9
  prom_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && prom) |=> res_accept);
endmodule

bind dest_addr_filter dest_addr_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da),
  .prom(prom_q), .station(slot_q[0]),
  .res_valid(res_valid), .res_accept(res_accept), .res_status(res_status)
);

// File: tb/dest_addr_filter_bench.sv
module dest_addr_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] STA  = 48'h6655_4433_2210;
  localparam logic [47:0] UNI2 = 48'h6655_4433_2212;
  localparam logic [47:0] MA   = 48'h1122_3344_5501;
  localparam logic [47:0] MB   = 48'h1122_3344_5503;
  localparam logic [47:0] MC   = 48'hA0B0_C0D0_E0F1;
  localparam logic [47:0] MD   = 48'h0102_0304_0507;
  localparam logic [47:0] BC   = 48'hFFFF_FFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic cfg_we = 1'b0, da_valid = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [47:0] da = '0;
  logic res_valid, res_accept;
  logic [5:0] res_status;

  dest_addr_filter u_dest_addr_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da(da),
    .res_valid(res_valid), .res_accept(res_accept), .res_status(res_status));

  int tests = 0, fails = 0;
  string cur_tag = "R2";

  logic [15:0] m_ctrl;
  logic [47:0] m_slot [4];
  logic [15:0] m_hash [4];
  logic e_valid = 1'b0, e_acc = 1'b0;
  logic [5:0] e_st = '0;
  string e_tag = "R1";

  function automatic logic [5:0] m_hidx(logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      c ^= {24'h0, a[8*b +: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c[31:26];
  endfunction

  function automatic logic [6:0] m_eval(logic [47:0] a);
    logic bc, mc, ex, hh;
    logic [1:0] idx;
    logic [5:0] h;
    logic [15:0] wd;
    bc = (a == BC);
    mc = a[0] && !bc;
    if (bc) return {1'b1, 6'h20};
    ex = 0; idx = 0;
    if (mc) begin
      for (int i = 3; i >= 1; i--)
        if (m_slot[i] == a && m_slot[i] != BC) begin ex = 1; idx = 2'(i); end
    end else if (m_slot[0] == a && m_slot[0] != BC) ex = 1;
    h  = m_hidx(a);
    wd = m_hash[h[5:4]];
    hh = mc && !ex && wd[15 - h[3:0]];
    return {m_ctrl[8] | ex | hh | (mc & m_ctrl[5]), 1'b0, mc, hh, ex, idx};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0;
      for (int i = 0; i < 4; i++) begin m_slot[i] = BC; m_hash[i] = '0; end
      e_valid = 0; e_acc = 0; e_st = 0; e_tag = "R1";
    end else begin
      e_valid = da_valid;
      if (da_valid) {e_acc, e_st} = m_eval(da);
      else {e_acc, e_st} = '0;
      e_tag = cur_tag;
      if (cfg_we && !cfg_addr[0]) begin
        if (cfg_addr == 8'h00) m_ctrl = cfg_wdata;
        else if (cfg_addr >= 8'h60 && cfg_addr < 8'h68)
          m_hash[(cfg_addr - 8'h60) / 2] = cfg_wdata;
        else if (cfg_addr >= 8'h68 && cfg_addr < 8'h88) begin
          int off;
          off = int'(cfg_addr) - 'h68;
          if (off % 8 < 6) m_slot[off / 8][16 * ((off % 8) / 2) +: 16] = cfg_wdata;
        end
      end
    end
  end

  always @(negedge clk) begin
    tests++;
    if (res_valid !== e_valid || res_accept !== e_acc || res_status !== e_st) begin
      fails++;
      $display("FAIL %s: valid=%0b accept=%0b status=%h expected valid=%0b accept=%0b status=%h",
               e_tag, res_valid, res_accept, res_status, e_valid, e_acc, e_st);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; da_valid = 0;
  endtask

  task automatic idle();
    @(negedge clk);
    cfg_we = 0; da_valid = 0; cur_tag = "R2";
  endtask

  task automatic wslot(input int i, input logic [47:0] a);
    wr(8'(8'h68 + 8 * i), a[15:0]);
    wr(8'(8'h6A + 8 * i), a[31:16]);
    wr(8'(8'h6C + 8 * i), a[47:32]);
  endtask

  task automatic sethash(input logic [47:0] a);
    logic [5:0] h;
    h = m_hidx(a);
    idle();
    wr(8'(8'h60 + 2 * h[5:4]), m_hash[h[5:4]] | (16'h8000 >> h[3:0]));
  endtask

  task automatic probe(input logic [47:0] a, input logic acc, input logic [5:0] st, input string tag);
    @(negedge clk);
    cfg_we = 0; da_valid = 1; da = a; cur_tag = tag;
    @(negedge clk);
    da_valid = 0;
    tests++;
    if (res_accept !== acc || res_status !== st || res_valid !== 1'b1) begin
      fails++;
      $display("FAIL %s: addr=%h accept=%0b status=%h expected accept=%0b status=%h",
               tag, a, res_accept, res_status, acc, st);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [6:0] ev;
    repeat (3) @(negedge clk);
    tests++;
    if (res_valid !== 0 || res_accept !== 0 || res_status !== 0) begin
      fails++;
      $display("FAIL R1: valid=%0b accept=%0b status=%h expected 0 0 00",
               res_valid, res_accept, res_status);
    end
    rst_n = 1;
    idle();
    probe(MA, 1'b0, 6'h10, "R1");

    wslot(0, STA);
    probe(STA, 1'b1, 6'h04, "R4");
    probe(UNI2, 1'b0, 6'h00, "R4");
    probe(BC, 1'b1, 6'h20, "R3");
    probe(MD, 1'b0, 6'h10, "R6");

    wslot(1, MA); wslot(2, MB); wslot(3, MB);
    probe(MA, 1'b1, 6'h15, "R5");
    probe(MB, 1'b1, 6'h16, "R5");
    wslot(2, BC);
    probe(MB, 1'b1, 6'h17, "R5");

    sethash(MC);
    probe(MC, 1'b1, 6'h18, "R6");
    sethash(MA);
    probe(MA, 1'b1, 6'h15, "R7");

    wr(8'h6E, 16'hBEEF); wr(8'h86, 16'h1234); wr(8'h02, 16'h0120); wr(8'h69, 16'h0000);
    probe(UNI2, 1'b0, 6'h00, "R10");
    probe(STA, 1'b1, 6'h04, "R10");
    probe(MA, 1'b1, 6'h15, "R10");

    wr(8'h00, 16'h0020);
    idle();
    ev = m_eval(MD);
    probe(MD, 1'b1, ev[5:0], "R8");
    probe(UNI2, 1'b0, 6'h00, "R8");

    wr(8'h00, 16'h0100);
    idle();
    probe(UNI2, 1'b1, 6'h00, "R9");
    ev = m_eval(MD);
    probe(MD, 1'b1, ev[5:0], "R9");
    probe(STA, 1'b1, 6'h04, "R9");

    wr(8'h00, 16'h0000);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      cfg_we = 0; da_valid = 1; cur_tag = "R2";
      da = (i % 2) ? MA : STA;
    end
    idle();

    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      cur_tag = "R6";
      cfg_we = ($urandom % 6) == 0;
      case ($urandom % 4)
        0: begin cfg_addr = 8'h00; cfg_wdata = 16'($urandom % 2) << 5 | 16'($urandom % 2) << 8; end
        1: begin cfg_addr = 8'(8'h60 + 2 * ($urandom % 4)); cfg_wdata = 16'($urandom); end
        2: begin cfg_addr = 8'(8'h68 + 8 * ($urandom % 4) + 2 * ($urandom % 3)); cfg_wdata = MB[15:0]; end
        default: begin cfg_addr = 8'($urandom); cfg_wdata = 16'($urandom); end
      endcase
      da_valid = ($urandom % 4) != 0;
      case ($urandom % 8)
        0: da = STA;
        1: da = UNI2;
        2: da = MA;
        3: da = MB;
        4: da = MC;
        5: da = BC;
        default: da = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      endcase
    end
    idle();
    repeat (3) idle();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule